// File: doc/BRIEF.md
# Open-Row Conflict Evaluator with Ready Throttle

This block sits on the controller side of a memory command path. A requester presents requests that carry a bank, a row, a column, a read/write select, a valid strobe and a single conflict hint. The requester raises the hint when the bank or the row differs from its own previous request. The requester cannot see which rows the controller still holds open, so the hint is only a guess. The block keeps its own table of which row is open in each bank. It uses the table to decide whether a flagged request is a real row miss or a false alarm.

A false alarm costs nothing: ready stays high and the read or write goes out two cycles after the request is presented. A real miss drops ready. The block then closes the bank's old row if there is one, opens the target row, waits a fixed gap and issues the access, and only then raises ready again. A request accepted in the cycle while a miss is still being evaluated is held and served afterwards, in order. A refresh input closes every bank at once and holds ready low while the refresh runs.

Top module: `rowgate_top`

## Requirements
- R1: After reset, ready is high, the command is idle and every bank is closed, so the first flagged access to any bank opens its row without a precharge.
- R2: A flagged request whose row is already open in its bank is a false conflict. Ready stays high and the read or write command appears two cycles after the request is presented, with no activate.
- R3: An unflagged request is taken as a hit without a table lookup. Its read or write appears two cycles after it is presented, and ready stays high.
- R4: A flagged request to a closed bank drops ready two cycles after presentation, and an activate carrying the row appears in that same cycle. After ACT_GAP idle cycles the access command appears, and ready is high again in that cycle.
- R5: A flagged request to a bank that has a different row open first issues a precharge to that bank, two cycles after presentation. PRE_GAP idle cycles follow, then the activate and the R4 tail. Ready stays low until the access cycle.
- R6: A row stays recorded as open across any number of accesses to other banks, until a precharge of its bank or a refresh closes it.
- R7: A request accepted in the cycle after a miss is held while the ready is low. Its command follows in the cycle right after the miss's access.
- R8: Back-to-back hits give one access command per cycle, and ready stays high.
- R9: A refresh request, taken when no request is pending, produces a close-all command in the next cycle and holds ready low for REF_CYC+1 cycles in total. After the refresh every bank is closed.
- R10: Command codes are idle=0, activate=1, precharge=2, close-all=3, read=4 and write=5. The address field carries the row on an activate and the column, zero-extended, on a read or write. On idle, precharge and close-all the address is zero. The bank field is zero on idle and close-all.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request strobe; taken when ready is high |
| req_bank | input | BANK_W | Target bank |
| req_row | input | ROW_W | Target row |
| req_col | input | COL_W | Target column |
| req_write | input | 1 | 1 = write, 0 = read |
| req_hint | input | 1 | Conflict hint (bank or row differs from the previous request) |
| refresh_req | input | 1 | Level request to close all banks |
| ready | output | 1 | Ready to accept a request |
| cmd_code | output | 3 | Command code (see R10) |
| cmd_bank | output | BANK_W | Command bank |
| cmd_addr | output | ROW_W | Row or zero-extended column |

## Verification
The assertions rely on the hint contract. An unflagged request must target the row used by the previous accepted request, with no refresh in between, so a missing hint never hides a real miss. They also assume that refresh is requested only while no request is in flight. The stimulus derives each hint from the bench's own record of the previous request and a refresh flag, adding forced hints only to provoke false conflicts. It raises refresh only in an idle cycle.

// File: rtl/rowgate_pkg.sv
package rowgate_pkg;

    typedef enum logic [2:0] {
        CMD_NOP  = 3'd0,
        CMD_ACT  = 3'd1,
        CMD_PRE  = 3'd2,
        CMD_PALL = 3'd3,
        CMD_RD   = 3'd4,
        CMD_WR   = 3'd5
    } cmd_e;

    typedef enum logic [1:0] {
        ST_RUN  = 2'd0,
        ST_PGAP = 2'd1,
        ST_AGAP = 2'd2,
        ST_REF  = 2'd3
    } seq_state_e;

endpackage

// File: rtl/rowgate_table.sv
module rowgate_table #(
    parameter  int BANKS  = 4,
    parameter  int ROW_W  = 14,
    localparam int BANK_W = (BANKS > 1) ? $clog2(BANKS) : 1
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          set_en,
    input  logic [BANK_W-1:0]             set_bank,
    input  logic [ROW_W-1:0]              set_row,
    input  logic                          clr_en,
    input  logic [BANK_W-1:0]             clr_bank,
    input  logic                          clr_all,
    input  logic [BANK_W-1:0]             look_bank,
    output logic                          look_valid,
    output logic [ROW_W-1:0]              look_row,
    output logic [BANKS-1:0]              open_vec
);

    typedef struct packed {
        logic [BANKS-1:0]            vld;
        logic [BANKS-1:0][ROW_W-1:0] row;
    } tbl_t;

    tbl_t tbl_q, tbl_d;

    // per-bank next-state slices
    for (genvar g = 0; g < BANKS; g++) begin : g_bank
        always_comb begin
            tbl_d.vld[g] = tbl_q.vld[g];
            tbl_d.row[g] = tbl_q.row[g];
            if (clr_all || (clr_en && clr_bank == BANK_W'(g))) begin
                tbl_d.vld[g] = 1'b0;
            end
            if (set_en && set_bank == BANK_W'(g)) begin
                tbl_d.vld[g] = 1'b1;
                tbl_d.row[g] = set_row;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tbl_q <= '0;
        end else begin
            tbl_q <= tbl_d;
        end
    end

    assign look_valid = tbl_q.vld[look_bank];
    assign look_row   = tbl_q.row[look_bank];
    assign open_vec   = tbl_q.vld;

    // R5
    act_needs_closed_chk: assert property (@(posedge clk) disable iff (!rst_n)
        set_en |-> !tbl_q.vld[set_bank]);

    // R6
    open_rows_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(set_en || clr_en || clr_all) |=> $stable(tbl_q.vld));

endmodule

// File: rtl/rowgate_seq.sv
module rowgate_seq
    import rowgate_pkg::*;
#(
    parameter  int BANKS   = 4,
    parameter  int ROW_W   = 14,
    parameter  int COL_W   = 10,
    parameter  int PRE_GAP = 1,
    parameter  int ACT_GAP = 1,
    parameter  int REF_CYC = 4,
    localparam int BANK_W  = (BANKS > 1) ? $clog2(BANKS) : 1,
    localparam int GAPMAX  = (PRE_GAP > ACT_GAP) ? PRE_GAP : ACT_GAP,
    localparam int CMAX    = (GAPMAX > REF_CYC) ? GAPMAX : REF_CYC,
    localparam int CNT_W   = $clog2(CMAX + 2)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic [BANK_W-1:0] req_bank,
    input  logic [ROW_W-1:0]  req_row,
    input  logic [COL_W-1:0]  req_col,
    input  logic              req_write,
    input  logic              req_hint,
    input  logic              refresh_req,
    input  logic              look_valid,
    input  logic [ROW_W-1:0]  look_row,
    output logic [BANK_W-1:0] look_bank,
    output logic              set_en,
    output logic [BANK_W-1:0] set_bank,
    output logic [ROW_W-1:0]  set_row,
    output logic              clr_en,
    output logic [BANK_W-1:0] clr_bank,
    output logic              clr_all,
    output logic              ready,
    output cmd_e              cmd,
    output logic [BANK_W-1:0] cmd_bank,
    output logic [ROW_W-1:0]  cmd_addr
);

    typedef struct packed {
        logic              v;
        logic [BANK_W-1:0] bank;
        logic [ROW_W-1:0]  row;
        logic [COL_W-1:0]  col;
        logic              wr;
        logic              hint;
    } req_t;

    typedef struct packed {
        seq_state_e        st;
        logic [CNT_W-1:0]  cnt;
        logic              rdy;
        req_t              cur;
        req_t              park;
        cmd_e              cmd;
        logic [BANK_W-1:0] cbank;
        logic [ROW_W-1:0]  caddr;
    } seq_t;

    seq_t q, d;
    req_t inc;
    logic hit;

    always_comb begin
        inc.v    = req_valid && q.rdy;
        inc.bank = req_bank;
        inc.row  = req_row;
        inc.col  = req_col;
        inc.wr   = req_write;
        inc.hint = req_hint;
    end

    assign look_bank = q.cur.bank;
    assign hit       = look_valid && (look_row == q.cur.row);

    always_comb begin
        d        = q;
        d.cmd    = CMD_NOP;
        d.cbank  = '0;
        d.caddr  = '0;
        set_en   = 1'b0;
        set_bank = q.cur.bank;
        set_row  = q.cur.row;
        clr_en   = 1'b0;
        clr_bank = q.cur.bank;
        clr_all  = 1'b0;

        unique case (q.st)
            ST_RUN: begin
                if (q.cur.v) begin
                    if (!q.cur.hint || hit) begin
                        d.cmd   = q.cur.wr ? CMD_WR : CMD_RD;
                        d.cbank = q.cur.bank;
                        d.caddr = ROW_W'(q.cur.col);
                        d.cur   = inc;
                    end else begin
                        d.rdy  = 1'b0;
                        d.park = inc;
                        d.cbank = q.cur.bank;
                        if (look_valid) begin
                            d.cmd  = CMD_PRE;
                            clr_en = 1'b1;
                            d.st   = ST_PGAP;
                            d.cnt  = CNT_W'(PRE_GAP);
                        end else begin
                            d.cmd   = CMD_ACT;
                            d.caddr = q.cur.row;
                            set_en  = 1'b1;
                            d.st    = ST_AGAP;
                            d.cnt   = CNT_W'(ACT_GAP);
                        end
                    end
                end else if (refresh_req) begin
                    d.rdy   = 1'b0;
                    d.park  = inc;
                    d.cmd   = CMD_PALL;
                    clr_all = 1'b1;
                    d.st    = ST_REF;
                    d.cnt   = CNT_W'(REF_CYC);
                end else begin
                    d.cur = inc;
                end
            end
            ST_PGAP: begin
                if (q.cnt == '0) begin
                    d.cmd   = CMD_ACT;
                    d.cbank = q.cur.bank;
                    d.caddr = q.cur.row;
                    set_en  = 1'b1;
                    d.st    = ST_AGAP;
                    d.cnt   = CNT_W'(ACT_GAP);
                end else begin
                    d.cnt = q.cnt - 1'b1;
                end
            end
            ST_AGAP: begin
                if (q.cnt == '0) begin
                    d.cmd   = q.cur.wr ? CMD_WR : CMD_RD;
                    d.cbank = q.cur.bank;
                    d.caddr = ROW_W'(q.cur.col);
                    d.rdy   = 1'b1;
                    d.st    = ST_RUN;
                    d.cur   = q.park;
                    d.park  = '0;
                end else begin
                    d.cnt = q.cnt - 1'b1;
                end
            end
            ST_REF: begin
                if (q.cnt == '0) begin
                    d.rdy  = 1'b1;
                    d.st   = ST_RUN;
                    d.cur  = q.park;
                    d.park = '0;
                end else begin
                    d.cnt = q.cnt - 1'b1;
                end
            end
            default: d.st = ST_RUN;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q     <= '0;
            q.st  <= ST_RUN;
            q.rdy <= 1'b1;
            q.cmd <= CMD_NOP;
        end else begin
            q <= d;
        end
    end

    assign ready    = q.rdy;
    assign cmd      = q.cmd;
    assign cmd_bank = q.cbank;
    assign cmd_addr = q.caddr;

    // R3
    unflagged_hit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (q.st == ST_RUN && q.cur.v && !q.cur.hint) |-> hit);

    // R4
    ready_drop_cmd_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(q.rdy) |-> (q.cmd == CMD_ACT || q.cmd == CMD_PRE || q.cmd == CMD_PALL));

    // R7
    parked_while_stalled_chk: assert property (@(posedge clk) disable iff (!rst_n)
        q.park.v |-> !q.rdy);

    // R9
    refresh_when_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        clr_all |-> !q.cur.v);

endmodule

// File: rtl/rowgate_top.sv
module rowgate_top
    import rowgate_pkg::*;
#(
    parameter  int BANKS   = 4,
    parameter  int ROW_W   = 14,
    parameter  int COL_W   = 10,
    parameter  int PRE_GAP = 1,
    parameter  int ACT_GAP = 1,
    parameter  int REF_CYC = 4,
    localparam int BANK_W  = (BANKS > 1) ? $clog2(BANKS) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic [BANK_W-1:0] req_bank,
    input  logic [ROW_W-1:0]  req_row,
    input  logic [COL_W-1:0]  req_col,
    input  logic              req_write,
    input  logic              req_hint,
    input  logic              refresh_req,
    output logic              ready,
    output logic [2:0]        cmd_code,
    output logic [BANK_W-1:0] cmd_bank,
    output logic [ROW_W-1:0]  cmd_addr
);

    logic              look_valid;
    logic [ROW_W-1:0]  look_row;
    logic [BANK_W-1:0] look_bank;
    logic              set_en;
    logic [BANK_W-1:0] set_bank;
    logic [ROW_W-1:0]  set_row;
    logic              clr_en;
    logic [BANK_W-1:0] clr_bank;
    logic              clr_all;
    logic [BANKS-1:0]  open_vec;
    cmd_e              cmd_w;

    rowgate_table #(
        .BANKS (BANKS),
        .ROW_W (ROW_W)
    ) u_table (
        .clk        (clk),
        .rst_n      (rst_n),
        .set_en     (set_en),
        .set_bank   (set_bank),
        .set_row    (set_row),
        .clr_en     (clr_en),
        .clr_bank   (clr_bank),
        .clr_all    (clr_all),
        .look_bank  (look_bank),
        .look_valid (look_valid),
        .look_row   (look_row),
        .open_vec   (open_vec)
    );

    rowgate_seq #(
        .BANKS   (BANKS),
        .ROW_W   (ROW_W),
        .COL_W   (COL_W),
        .PRE_GAP (PRE_GAP),
        .ACT_GAP (ACT_GAP),
        .REF_CYC (REF_CYC)
    ) u_seq (
        .clk         (clk),
        .rst_n       (rst_n),
        .req_valid   (req_valid),
        .req_bank    (req_bank),
        .req_row     (req_row),
        .req_col     (req_col),
        .req_write   (req_write),
        .req_hint    (req_hint),
        .refresh_req (refresh_req),
        .look_valid  (look_valid),
        .look_row    (look_row),
        .look_bank   (look_bank),
        .set_en      (set_en),
        .set_bank    (set_bank),
        .set_row     (set_row),
        .clr_en      (clr_en),
        .clr_bank    (clr_bank),
        .clr_all     (clr_all),
        .ready       (ready),
        .cmd         (cmd_w),
        .cmd_bank    (cmd_bank),
        .cmd_addr    (cmd_addr)
    );

    assign cmd_code = cmd_w;

    // R2
    access_to_open_bank_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_w == CMD_RD || cmd_w == CMD_WR) |-> open_vec[cmd_bank]);

    // R9
    all_closed_after_refresh_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_w == CMD_PALL) |-> (open_vec == '0));

    // R10
    act_row_recorded_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_w == CMD_ACT) |-> open_vec[cmd_bank]);

endmodule

// File: tb/rowgate_top_tb.sv
module rowgate_top_tb;

    localparam int CLK_PERIOD = 10;
    localparam int BANKS   = 4;
    localparam int ROW_W   = 14;
    localparam int COL_W   = 10;
    localparam int PRE_GAP = 1;
    localparam int ACT_GAP = 1;
    localparam int REF_CYC = 4;
    localparam int BANK_W  = 2;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              req_valid = 1'b0;
    logic [BANK_W-1:0] req_bank = '0;
    logic [ROW_W-1:0]  req_row = '0;
    logic [COL_W-1:0]  req_col = '0;
    logic              req_write = 1'b0;
    logic              req_hint = 1'b0;
    logic              refresh_req = 1'b0;
    logic              ready;
    logic [2:0]        cmd_code;
    logic [BANK_W-1:0] cmd_bank;
    logic [ROW_W-1:0]  cmd_addr;

    int errs = 0;
    int checks = 0;
    bit mo[BANKS];
    int mr[BANKS];
    int pb = -1;
    int pr = -1;
    bit refd = 1'b1;

    always #(CLK_PERIOD/2) clk = ~clk;

    rowgate_top #(
        .BANKS(BANKS), .ROW_W(ROW_W), .COL_W(COL_W),
        .PRE_GAP(PRE_GAP), .ACT_GAP(ACT_GAP), .REF_CYC(REF_CYC)
    ) u_dut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_bank(req_bank),
        .req_row(req_row), .req_col(req_col), .req_write(req_write),
        .req_hint(req_hint), .refresh_req(refresh_req), .ready(ready),
        .cmd_code(cmd_code), .cmd_bank(cmd_bank), .cmd_addr(cmd_addr)
    );

    task automatic expect_cmd(input string tag, input int code, input int bank,
                              input int addr, input bit rdy);
        checks++;
        if (cmd_code !== 3'(code) || cmd_bank !== BANK_W'(bank) ||
            cmd_addr !== ROW_W'(addr) || ready !== rdy) begin
            errs++;
            $display("FAIL %s: got code=%0d bank=%0d addr=%0d ready=%0d, expected code=%0d bank=%0d addr=%0d ready=%0d",
                     tag, cmd_code, cmd_bank, cmd_addr, ready, code, bank, addr, rdy);
        end
    endtask

    task automatic drive(input int b, input int r, input int c, input bit wr, input bit h);
        req_valid = 1'b1;
        req_bank  = BANK_W'(b);
        req_row   = ROW_W'(r);
        req_col   = COL_W'(c);
        req_write = wr;
        req_hint  = h;
    endtask

    // Present one request at the current falling edge and follow its command stream.
    task automatic do_req(input int b, input int r, input int c, input bit wr,
                          input bit hint, input string ovr);
        bit miss;
        string tag;
        int rw;
        miss = hint && !(mo[b] && mr[b] == r);
        if (ovr != "") tag = ovr;
        else if (!hint) tag = "R3";
        else if (!miss) tag = "R2";
        else if (mo[b]) tag = "R5";
        else tag = "R4";
        rw = wr ? 5 : 4;
        drive(b, r, c, wr, hint);
        @(negedge clk);
        req_valid = 1'b0;
        expect_cmd(tag, 0, 0, 0, 1'b1);
        @(negedge clk);
        if (!miss) begin
            expect_cmd(tag, rw, b, c, 1'b1);
        end else begin
            if (mo[b]) begin
                expect_cmd(tag, 2, b, 0, 1'b0);
                for (int k = 0; k < PRE_GAP; k++) begin
                    @(negedge clk);
                    expect_cmd(tag, 0, 0, 0, 1'b0);
                end
                @(negedge clk);
            end
            expect_cmd(tag, 1, b, r, 1'b0);
            for (int k = 0; k < ACT_GAP; k++) begin
                @(negedge clk);
                expect_cmd(tag, 0, 0, 0, 1'b0);
            end
            @(negedge clk);
            expect_cmd(tag, rw, b, c, 1'b1);
            mo[b] = 1'b1;
            mr[b] = r;
        end
        @(negedge clk);
        pb = b;
        pr = r;
        refd = 1'b0;
    endtask

    task automatic sweep_req(input int b, input int r, input int c, input bit wr, input bit force_h);
        bit h;
        h = force_h || b != pb || r != pr || refd;
        do_req(b, r, c, wr, h, "");
    endtask

    task automatic do_refresh();
        refresh_req = 1'b1;
        @(negedge clk);
        expect_cmd("R9", 3, 0, 0, 1'b0);
        refresh_req = 1'b0;
        for (int k = 0; k < REF_CYC; k++) begin
            @(negedge clk);
            expect_cmd("R9", 0, 0, 0, 1'b0);
        end
        @(negedge clk);
        expect_cmd("R9", 0, 0, 0, 1'b1);
        for (int k = 0; k < BANKS; k++) mo[k] = 1'b0;
        refd = 1'b1;
    endtask

    // R7: second request arrives while the first (a miss to a closed bank) is evaluated
    task automatic park_test(input int b, input int r, input int c1, input int c2);
        drive(b, r, c1, 1'b1, 1'b1);
        @(negedge clk);
        expect_cmd("R7", 0, 0, 0, 1'b1);
        drive(b, r, c2, 1'b0, 1'b0);
        @(negedge clk);
        req_valid = 1'b0;
        expect_cmd("R7", 1, b, r, 1'b0);
        for (int k = 0; k < ACT_GAP; k++) begin
            @(negedge clk);
            expect_cmd("R7", 0, 0, 0, 1'b0);
        end
        @(negedge clk);
        expect_cmd("R7", 5, b, c1, 1'b1);
        @(negedge clk);
        expect_cmd("R7", 4, b, c2, 1'b1);
        @(negedge clk);
        expect_cmd("R7", 0, 0, 0, 1'b1);
        mo[b] = 1'b1;
        mr[b] = r;
        pb = b;
        pr = r;
        refd = 1'b0;
    endtask

    // R8: two hits on consecutive cycles
    task automatic b2b_test(input int b1, input int r1, input int b2, input int r2);
        drive(b1, r1, 17, 1'b0, 1'b1);
        @(negedge clk);
        expect_cmd("R8", 0, 0, 0, 1'b1);
        drive(b2, r2, 18, 1'b1, 1'b1);
        @(negedge clk);
        req_valid = 1'b0;
        expect_cmd("R8", 4, b1, 17, 1'b1);
        @(negedge clk);
        expect_cmd("R8", 5, b2, 18, 1'b1);
        @(negedge clk);
        expect_cmd("R8", 0, 0, 0, 1'b1);
        pb = b2;
        pr = r2;
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        errs++;
        $display("FAIL watchdog: got hung run, expected completion");
        $display("Result: errors=%0d of %0d checks", errs, checks + 1);
        $finish;
    end

    initial begin
        for (int k = 0; k < BANKS; k++) begin
            mo[k] = 1'b0;
            mr[k] = 0;
        end
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        expect_cmd("R1", 0, 0, 0, 1'b1);
        do_req(0, 3, 12, 1'b0, 1'b1, "R1");
        do_req(1, 3, 13, 1'b1, 1'b1, "R1");

        for (int rep = 0; rep < 3; rep++) begin
            for (int i = 0; i < 16; i++) begin
                sweep_req((i + rep) % BANKS, (i / 4 + rep * (i % 4)) % 4,
                          (i * 37 + rep * 5) % 1024, i[0], rep == 1);
            end
            do_refresh();
        end

        // R6: bank 0 row stays open across other-bank traffic
        do_req(0, 9, 1, 1'b0, 1'b1, "");
        do_req(1, 9, 2, 1'b0, 1'b1, "");
        do_req(2, 9, 3, 1'b1, 1'b1, "");
        do_req(3, 9, 4, 1'b0, 1'b1, "");
        do_req(0, 9, 5, 1'b1, 1'b1, "R6");

        // R9: refresh closes a row that was open
        do_refresh();
        do_req(0, 9, 6, 1'b0, 1'b1, "R9");

        do_refresh();
        park_test(2, 4, 100, 101);

        do_req(0, 5, 7, 1'b0, 1'b1, "");
        do_req(1, 6, 8, 1'b1, 1'b1, "");
        b2b_test(0, 5, 1, 6);

        // R10: full-width column zero-extended on a write, read code on a read
        do_req(1, 6, 1023, 1'b1, 1'b1, "R10");
        do_req(1, 6, 512, 1'b0, 1'b0, "R10");

        $display("Result: errors=%0d of %0d checks", errs, checks);
        $finish;
    end

endmodule